// File: doc/BRIEF.md
# Debug Download Mailbox

This block sits between a JTAG host and a debug handler that runs on the processor. It lets the two sides agree on when code may be pushed into the instruction cache while the processor keeps running. On the JTAG side, a 2-bit instruction register picks one of four data paths: a one-bit bypass, a transmit path (processor to host), a receive path (host to processor) and a cache-load path. The TAP controller is outside the block. It reaches the block only as capture, shift and update strobes that are sampled on TCK. Bits shift least significant first on `tdi`/`tdo`.

On the processor side, a small register port gives the handler a transmit register, a control register and the last word received from the host. The handshake is cross-coupled. When the handler writes the transmit word, a ready flag is raised on the host side. When the host updates the receive path, control bit 31 is cleared on the processor side. The handler polls that bit to learn that the download has finished. Each crossing between the two clock domains uses a held data word and a toggle, which passes through a two-flop synchroniser.

The cache-load path collects one cache line per scan: a 32-bit line address followed by eight 32-bit words. A scan of exactly the right length produces an invalidate pulse for the line and then a line-write pulse that carries the data. A scan of any other length is dropped.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the instruction register holds 0 (bypass), the ready flag is 0, control bit 31 reads 1, the received word reads 0, and `ic_inval` and `ic_wr` are low.
- R2: An `ir_update` strobe loads `ir_in` into the instruction register, which is shown on `jtag_ir`. The encodings are 0 bypass, 1 transmit, 2 receive, 3 cache load. In bypass the data path is one flop, which captures 0.
- R3: A processor write to register 0 raises the ready flag a few TCK cycles later. The word captured with it equals the written word.
- R4: A capture under the transmit instruction loads 33 bits: the ready flag in bit 0 and the transmit word in bits 32..1. The capture clears the ready flag, so the next capture shows 0 until a new word arrives.
- R5: If a word arrives in the same TCK cycle as a transmit capture, the arrival wins. The host sees that word exactly once, in the current scan or the next one.
- R6: A processor write to register 1 with bit 31 set sets control bit 31. A write with bit 31 clear leaves it unchanged.
- R7: An update under the receive instruction clears control bit 31 exactly once. It also stores the 32 shifted bits, with the first bit shifted as bit 0, as the received word. If the clear and a processor set fall in the same cycle, the clear wins.
- R8: An update under any instruction other than receive leaves control bit 31 and the received word unchanged.
- R9: Under the cache-load instruction, a scan of exactly 288 bits followed by an update pulses `ic_inval` for one TCK cycle with `ic_addr` set to the first 32 bits shifted. In the next cycle it pulses `ic_wr` with the same address and `ic_line`, where word k sits in bits 32k+31..32k.
- R10: A cache-load scan shorter or longer than 288 bits produces no pulse. Each capture starts a new count.
- R11: Processor reads return the last transmit word at address 0, `{bit31, 31'b0}` at address 1, the received word at address 2 and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Processor-domain synchronous reset, active low |
| tck | input | 1 | JTAG test clock |
| tck_rst_n | input | 1 | TCK-domain synchronous reset, active low |
| ir_update | input | 1 | Load `ir_in` into the instruction register |
| ir_in | input | 2 | Instruction to load |
| dr_capture | input | 1 | Capture strobe for the selected data path |
| dr_shift | input | 1 | Shift strobe for the selected data path |
| dr_update | input | 1 | Update strobe for the selected data path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected path |
| jtag_ir | output | 2 | Current instruction |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | Write enable |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational |
| ic_inval | output | 1 | Invalidate request for `ic_addr` |
| ic_wr | output | 1 | Line write for `ic_addr` |
| ic_addr | output | 32 | Target line address |
| ic_line | output | 256 | Line data, word 0 in the low bits |

## Verification
Two events can fall in the same TCK cycle: a transmit word arriving from the processor domain and the host capturing the transmit path, which clears the ready flag. The bench provokes this by moving the processor write across twelve processor-clock offsets, one step at a time, in front of a fixed host capture. Every word has to be seen exactly once, with the ready flag set, either in that scan or the one after it, and a further capture must then show the flag clear. An assertion requires the flag to be set in the cycle after any arrival, including when the arrival coincides with a capture.

// File: rtl/mbx_pkg.sv
// Shared encodings for the debug download mailbox.
// Assumes: a 2-bit instruction register and a 4-entry processor register port.
package mbx_pkg;

    typedef enum logic [1:0] {
        INS_BYPASS  = 2'd0,
        INS_DBG_TX  = 2'd1,
        INS_DBG_RX  = 2'd2,
        INS_LOAD_IC = 2'd3
    } mbx_ins_e;

    localparam logic [1:0] REG_TX   = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_RX   = 2'd2;

    localparam int CTRL_BUSY_BIT = 31;

endpackage

// File: rtl/mbx_tgl_sync.sv
// Single-word clock-domain crossing built from a held word and a toggle.
// The source holds the word and flips a toggle. The destination passes the
// toggle through two flops and, on an edge, emits a one-cycle pulse while the
// held word is already stable.
// Assumes: the source issues no new request until the previous one has
// reached the destination (the mailbox handshake guarantees this).
module mbx_tgl_sync #(
    parameter int W = 32
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         src_req,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);

    localparam int STAGES = 3;

    logic [W-1:0]      hold_q;
    logic              tgl_q;
    logic [STAGES-1:0] sync_q;

    // Source side: latch the word and flip the toggle on each request.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            hold_q <= '0;
            tgl_q  <= 1'b0;
        end else if (src_req) begin
            hold_q <= src_data;
            tgl_q  <= ~tgl_q;
        end
    end

    // Destination side: two metastability flops plus one flop for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tgl_q};
        end
    end

    assign dst_pulse = sync_q[STAGES-1] ^ sync_q[STAGES-2];
    assign dst_data  = hold_q;

endmodule

// File: rtl/mbx_jtag_side.sv
// TCK-domain front end: the instruction register, the transmit, receive and
// bypass data registers, the ready flag and the tdo multiplexer.
// Assumes: capture, shift and update strobes are mutually exclusive and
// last one TCK cycle each; bits shift least significant first.
module mbx_jtag_side
    import mbx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic              ir_update,
    input  logic [1:0]        ir_in,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    input  logic              ldic_tdo,
    input  logic              tx_arrive,
    input  logic [WORD_W-1:0] tx_word,
    output logic [1:0]        ir_q,
    output logic              tx_ready,
    output logic              rx_req,
    output logic [WORD_W-1:0] rx_word,
    output logic              sel_ldic,
    output logic              tdo
);

    localparam int TX_LEN = WORD_W + 1;

    mbx_ins_e          ir_r;
    logic [WORD_W-1:0] tx_q;
    logic [TX_LEN-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic              byp_q;
    logic              sel_tx;
    logic              sel_rx;
    logic              sel_byp;

    assign sel_tx   = (ir_r == INS_DBG_TX);
    assign sel_rx   = (ir_r == INS_DBG_RX);
    assign sel_byp  = (ir_r == INS_BYPASS);
    assign sel_ldic = (ir_r == INS_LOAD_IC);

    // Instruction register: load on update; reset selects bypass.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            ir_r <= INS_BYPASS;
        end else if (ir_update) begin
            ir_r <= mbx_ins_e'(ir_in);
        end
    end

    // Transmit word and ready flag: an arrival beats a consuming capture.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            tx_q     <= '0;
            tx_ready <= 1'b0;
        end else if (tx_arrive) begin
            tx_q     <= tx_word;
            tx_ready <= 1'b1;
        end else if (dr_capture && sel_tx) begin
            tx_ready <= 1'b0;
        end
    end

    // Transmit shift register: capture {word, ready}, shift toward tdo.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            tx_sr <= '0;
        end else if (sel_tx && dr_capture) begin
            tx_sr <= {tx_q, tx_ready};
        end else if (sel_tx && dr_shift) begin
            tx_sr <= {tdi, tx_sr[TX_LEN-1:1]};
        end
    end

    // Receive shift register: collect host bits; first bit ends up in bit 0.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            rx_sr <= '0;
        end else if (sel_rx && dr_shift) begin
            rx_sr <= {tdi, rx_sr[WORD_W-1:1]};
        end
    end

    // Bypass register: one flop that captures zero.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            byp_q <= 1'b0;
        end else if (sel_byp && dr_capture) begin
            byp_q <= 1'b0;
        end else if (sel_byp && dr_shift) begin
            byp_q <= tdi;
        end
    end

    assign rx_req  = sel_rx && dr_update;
    assign rx_word = rx_sr;
    assign ir_q    = ir_r;

    // Serial output: bit 0 of whichever path the instruction selects.
    always_comb begin
        case (ir_r)
            INS_DBG_TX:  tdo = tx_sr[0];
            INS_DBG_RX:  tdo = rx_sr[0];
            INS_LOAD_IC: tdo = ldic_tdo;
            default:     tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/mbx_line_loader.sv
// Cache-load data path: gathers an address word and LINE_WORDS data words
// from one scan. An update after a scan of exact length issues an invalidate
// pulse, then a line-write pulse in the next cycle. Any other length is dropped.
// Assumes: the first word shifted is the line address; capture starts a scan.
module mbx_line_loader #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                         tck,
    input  logic                         tck_rst_n,
    input  logic                         sel,
    input  logic                         dr_capture,
    input  logic                         dr_shift,
    input  logic                         dr_update,
    input  logic                         tdi,
    output logic                         tdo,
    output logic                         ic_inval,
    output logic                         ic_wr,
    output logic [WORD_W-1:0]            ic_addr,
    output logic [WORD_W*LINE_WORDS-1:0] ic_line
);

    localparam int LINE_W = WORD_W * LINE_WORDS;
    localparam int TOTAL  = LINE_W + WORD_W;
    localparam int CNT_W  = $clog2(TOTAL + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TOTAL);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(TOTAL + 1);

    logic [TOTAL-1:0] sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    assign fire = sel && dr_update && (cnt_q == CNT_FULL);

    // Scan shifter: new bits enter at the top, so the first bit lands in bit 0.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            sr_q <= '0;
        end else if (sel && dr_shift) begin
            sr_q <= {tdi, sr_q[TOTAL-1:1]};
        end
    end

    // Bit counter: restart on capture, saturate one past full length.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            cnt_q <= '0;
        end else if (sel && dr_capture) begin
            cnt_q <= '0;
        end else if (sel && dr_shift && (cnt_q != CNT_OVER)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output sequencer: invalidate first, line write in the next cycle.
    always_ff @(posedge tck) begin
        if (!tck_rst_n) begin
            ic_inval <= 1'b0;
            ic_wr    <= 1'b0;
            ic_addr  <= '0;
            ic_line  <= '0;
        end else begin
            ic_inval <= fire;
            ic_wr    <= ic_inval;
            if (fire) begin
                ic_addr <= sr_q[WORD_W-1:0];
                ic_line <= sr_q[TOTAL-1:WORD_W];
            end
        end
    end

    assign tdo = sr_q[0];

endmodule

// File: rtl/mbx_cpu_regs.sv
// Processor-side registers: the transmit word, the control register whose
// bit 31 blocks the handler, and the word last received from the host.
// Assumes: single-cycle accesses; reads are combinational.
module mbx_cpu_regs
    import mbx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              tx_req,
    output logic [WORD_W-1:0] tx_data,
    input  logic              rx_done,
    input  logic [WORD_W-1:0] rx_data,
    output logic              busy
);

    logic [WORD_W-1:0] tx_last_q;
    logic [WORD_W-1:0] rx_q;
    logic              wr_tx;
    logic              wr_ctrl_set;

    assign wr_tx       = cpu_sel && cpu_we && (cpu_addr == REG_TX);
    assign wr_ctrl_set = cpu_sel && cpu_we && (cpu_addr == REG_CTRL)
                         && cpu_wdata[CTRL_BUSY_BIT];

    // Transmit register copy kept for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_last_q <= '0;
        end else if (wr_tx) begin
            tx_last_q <= cpu_wdata;
        end
    end

    // Busy bit: reset set; the host's done clear beats a handler set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
        end else if (rx_done) begin
            busy <= 1'b0;
        end else if (wr_ctrl_set) begin
            busy <= 1'b1;
        end
    end

    // Received word, written when the host update arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rx_done) begin
            rx_q <= rx_data;
        end
    end

    // Read multiplexer.
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            REG_TX:   cpu_rdata = tx_last_q;
            REG_CTRL: cpu_rdata[CTRL_BUSY_BIT] = busy;
            REG_RX:   cpu_rdata = rx_q;
            default:  cpu_rdata = '0;
        endcase
    end

    assign tx_req  = wr_tx;
    assign tx_data = cpu_wdata;

endmodule

// File: rtl/dbg_mailbox.sv
// Top level of the debug download mailbox: joins the TCK front end, the
// cache-load path, the processor registers and the two word crossings.
// Assumes: tck and clk are unrelated; each domain has its own synchronous
// active-low reset.
module dbg_mailbox #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tck,
    input  logic                         tck_rst_n,
    input  logic                         ir_update,
    input  logic [1:0]                   ir_in,
    input  logic                         dr_capture,
    input  logic                         dr_shift,
    input  logic                         dr_update,
    input  logic                         tdi,
    output logic                         tdo,
    output logic [1:0]                   jtag_ir,
    input  logic                         cpu_sel,
    input  logic                         cpu_we,
    input  logic [1:0]                   cpu_addr,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic [WORD_W-1:0]            cpu_rdata,
    output logic                         ic_inval,
    output logic                         ic_wr,
    output logic [WORD_W-1:0]            ic_addr,
    output logic [WORD_W*LINE_WORDS-1:0] ic_line
);

    logic              tx_req;
    logic [WORD_W-1:0] tx_data;
    logic              tx_arrive;
    logic [WORD_W-1:0] tx_word;
    logic              tx_ready;
    logic              rx_req;
    logic [WORD_W-1:0] rx_word;
    logic              rx_done;
    logic [WORD_W-1:0] rx_data;
    logic              busy;
    logic              sel_ldic;
    logic              ldic_tdo;

    mbx_jtag_side #(.WORD_W(WORD_W)) u_jtag (
        .tck        (tck),
        .tck_rst_n  (tck_rst_n),
        .ir_update  (ir_update),
        .ir_in      (ir_in),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .tdi        (tdi),
        .ldic_tdo   (ldic_tdo),
        .tx_arrive  (tx_arrive),
        .tx_word    (tx_word),
        .ir_q       (jtag_ir),
        .tx_ready   (tx_ready),
        .rx_req     (rx_req),
        .rx_word    (rx_word),
        .sel_ldic   (sel_ldic),
        .tdo        (tdo)
    );

    mbx_line_loader #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_line (
        .tck        (tck),
        .tck_rst_n  (tck_rst_n),
        .sel        (sel_ldic),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .tdi        (tdi),
        .tdo        (ldic_tdo),
        .ic_inval   (ic_inval),
        .ic_wr      (ic_wr),
        .ic_addr    (ic_addr),
        .ic_line    (ic_line)
    );

    mbx_cpu_regs #(.WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel    (cpu_sel),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .tx_req     (tx_req),
        .tx_data    (tx_data),
        .rx_done    (rx_done),
        .rx_data    (rx_data),
        .busy       (busy)
    );

    // Processor to host: transmit word.
    mbx_tgl_sync #(.W(WORD_W)) u_tx_cdc (
        .src_clk    (clk),
        .src_rst_n  (rst_n),
        .src_req    (tx_req),
        .src_data   (tx_data),
        .dst_clk    (tck),
        .dst_rst_n  (tck_rst_n),
        .dst_pulse  (tx_arrive),
        .dst_data   (tx_word)
    );

    // Host to processor: received word and done event.
    mbx_tgl_sync #(.W(WORD_W)) u_rx_cdc (
        .src_clk    (tck),
        .src_rst_n  (tck_rst_n),
        .src_req    (rx_req),
        .src_data   (rx_word),
        .dst_clk    (clk),
        .dst_rst_n  (rst_n),
        .dst_pulse  (rx_done),
        .dst_data   (rx_data)
    );

endmodule

// File: rtl/mbx_checker.sv
// Property checker for the mailbox, attached to every dbg_mailbox by bind.
// Assumes: it observes the top's ports and the nets that join its submodules.
module mbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tck,
    input logic        tck_rst_n,
    input logic        dr_capture,
    input logic [1:0]  jtag_ir,
    input logic        cpu_sel,
    input logic        cpu_we,
    input logic [1:0]  cpu_addr,
    input logic [31:0] cpu_wdata,
    input logic        tx_arrive,
    input logic        tx_ready,
    input logic        rx_done,
    input logic        busy,
    input logic        ic_inval,
    input logic        ic_wr
);

    AST_READY_SET_ON_ARRIVAL: assert property (@(posedge tck) disable iff (!tck_rst_n)
        tx_arrive |=> tx_ready); // R3

    AST_READY_DROP_NEEDS_CAPTURE: assert property (@(posedge tck) disable iff (!tck_rst_n)
        $fell(tx_ready) |-> $past(dr_capture && (jtag_ir == 2'd1))); // R4

    AST_ARRIVAL_WINS_COLLISION: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (tx_arrive && dr_capture && (jtag_ir == 2'd1)) |=> tx_ready); // R5

    AST_BUSY_SET_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cpu_sel && cpu_we && (cpu_addr == 2'd1) && cpu_wdata[31])); // R6

    AST_BUSY_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !busy); // R7

    AST_WRITE_FOLLOWS_INVAL: assert property (@(posedge tck) disable iff (!tck_rst_n)
        ic_inval |=> (ic_wr && !ic_inval)); // R9

    AST_WRITE_SINGLE: assert property (@(posedge tck) disable iff (!tck_rst_n)
        ic_wr |=> !ic_wr); // R9

    AST_NO_PULSE_OVERLAP: assert property (@(posedge tck) disable iff (!tck_rst_n)
        ic_inval |-> !ic_wr); // R9

endmodule

bind dbg_mailbox mbx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tck        (tck),
    .tck_rst_n  (tck_rst_n),
    .dr_capture (dr_capture),
    .jtag_ir    (jtag_ir),
    .cpu_sel    (cpu_sel),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata[31:0]),
    .tx_arrive  (tx_arrive),
    .tx_ready   (tx_ready),
    .rx_done    (rx_done),
    .busy       (busy),
    .ic_inval   (ic_inval),
    .ic_wr      (ic_wr)
);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;

    logic         clk = 1'b0;
    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tck_rst_n = 1'b0;
    logic         ir_update = 1'b0;
    logic [1:0]   ir_in = 2'd0;
    logic         dr_capture = 1'b0;
    logic         dr_shift = 1'b0;
    logic         dr_update = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic [1:0]   jtag_ir;
    logic         cpu_sel = 1'b0;
    logic         cpu_we = 1'b0;
    logic [1:0]   cpu_addr = 2'd0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         ic_inval;
    logic         ic_wr;
    logic [31:0]  ic_addr;
    logic [255:0] ic_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz processor clock
    always #10  tck = ~tck;   // 50 MHz test clock

    dbg_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tck_rst_n(tck_rst_n),
        .ir_update(ir_update), .ir_in(ir_in), .dr_capture(dr_capture),
        .dr_shift(dr_shift), .dr_update(dr_update), .tdi(tdi), .tdo(tdo),
        .jtag_ir(jtag_ir), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ic_inval(ic_inval), .ic_wr(ic_wr), .ic_addr(ic_addr), .ic_line(ic_line)
    );

    // {transmit word, receive word}
    localparam logic [63:0] VEC [6] = '{
        64'h0000_0001_FFFF_FFFE,
        64'hDEAD_BEEF_1234_5678,
        64'hFFFF_FFFF_0000_0000,
        64'h8000_0000_0000_0001,
        64'hA5A5_5A5A_C3C3_3C3C,
        64'h0F0F_F0F0_8000_0001
    };

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic ir_load(input logic [1:0] v);
        @(negedge tck);
        ir_update = 1'b1; ir_in = v;
        @(negedge tck);
        ir_update = 1'b0;
    endtask

    // Capture the transmit path and shift out its 33 bits.
    task automatic tx_scan(output logic rdy, output logic [31:0] w);
        logic [32:0] cap;
        @(negedge tck);
        dr_capture = 1'b1;
        @(negedge tck);
        dr_capture = 1'b0;
        for (int i = 0; i < 33; i++) begin
            dr_shift = 1'b1; tdi = 1'b0;
            cap[i] = tdo;
            @(negedge tck);
        end
        dr_shift = 1'b0;
        rdy = cap[0];
        w = cap[32:1];
    endtask

    // Capture, shift n bits of v (bit 0 first), then update.
    task automatic scan_bits(input logic [319:0] v, input int n);
        @(negedge tck);
        dr_capture = 1'b1;
        @(negedge tck);
        dr_capture = 1'b0;
        for (int i = 0; i < n; i++) begin
            dr_shift = 1'b1; tdi = v[i];
            @(negedge tck);
        end
        dr_shift = 1'b0;
        dr_update = 1'b1;
        @(negedge tck);
        dr_update = 1'b0;
    endtask

    task automatic no_pulse(input string req);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < 3; i++) begin
            seen = seen | ic_inval | ic_wr;
            @(negedge tck);
        end
        chk(req, {255'd0, seen}, 256'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic        r;
        logic [31:0] d;
        logic [319:0] lv;

        repeat (6) @(negedge tck);
        rst_n = 1'b1; tck_rst_n = 1'b1;
        repeat (2) @(negedge tck);

        // R1: reset state
        chk("R1 ir", {254'd0, jtag_ir}, 256'd0);
        chk("R1 pulses", {254'd0, ic_inval, ic_wr}, 256'd0);
        cpu_read(2'd1, d); chk("R1 ctrl", {224'd0, d}, {224'd0, 32'h8000_0000});
        cpu_read(2'd2, d); chk("R1 rx word", {224'd0, d}, 256'd0);
        ir_load(2'd1);
        chk("R2 ir load", {254'd0, jtag_ir}, 256'd1);
        tx_scan(r, d);
        chk("R1 ready", {223'd0, d, r}, 256'd0);

        // R2: bypass is one flop that captures 0
        ir_load(2'd0);
        @(negedge tck); dr_capture = 1'b1;
        @(negedge tck); dr_capture = 1'b0; dr_shift = 1'b1; tdi = 1'b1;
        chk("R2 bypass capture", {255'd0, tdo}, 256'd0);
        @(negedge tck); dr_shift = 1'b0;
        chk("R2 bypass shift", {255'd0, tdo}, 256'd1);

        // R8: updates under bypass and transmit leave ctrl and rx word alone
        scan_bits(320'h1, 1);
        ir_load(2'd1);
        scan_bits(320'hFFFF_FFFF_F, 33);
        repeat (12) @(negedge clk);
        cpu_read(2'd1, d); chk("R8 ctrl kept", {224'd0, d}, {224'd0, 32'h8000_0000});
        cpu_read(2'd2, d); chk("R8 rx kept", {224'd0, d}, 256'd0);

        // Vector table: full handshake per entry
        for (int k = 0; k < 6; k++) begin
            logic [31:0] txw, rxw;
            txw = VEC[k][63:32];
            rxw = VEC[k][31:0];
            ir_load(2'd1);
            cpu_write(2'd0, txw);
            r = 1'b0;
            for (int p = 0; p < 4 && !r; p++) tx_scan(r, d);
            chk("R3 ready seen", {255'd0, r}, 256'd1);
            chk("R4 tx word", {224'd0, d}, {224'd0, txw});
            tx_scan(r, d);
            chk("R4 ready cleared", {255'd0, r}, 256'd0);
            ir_load(2'd2);
            scan_bits({288'd0, rxw}, 32);
            repeat (12) @(negedge clk);
            cpu_read(2'd1, d); chk("R7 busy cleared", {224'd0, d}, 256'd0);
            cpu_read(2'd2, d); chk("R7 rx word", {224'd0, d}, {224'd0, rxw});
            cpu_read(2'd0, d); chk("R11 tx readback", {224'd0, d}, {224'd0, txw});
            cpu_read(2'd3, d); chk("R11 addr3 zero", {224'd0, d}, 256'd0);
            cpu_write(2'd1, 32'h8000_0000);
            cpu_read(2'd1, d); chk("R6 busy set", {224'd0, d}, {224'd0, 32'h8000_0000});
        end

        // R6: write with bit 31 clear has no effect
        ir_load(2'd2);
        scan_bits(320'h55, 32);
        repeat (12) @(negedge clk);
        cpu_write(2'd1, 32'h7FFF_FFFF);
        cpu_read(2'd1, d); chk("R6 write0 ignored", {224'd0, d}, 256'd0);
        cpu_write(2'd1, 32'h8000_0000);

        // R5: sweep arrival against a fixed capture
        ir_load(2'd1);
        for (int off = 0; off < 12; off++) begin
            logic [31:0] w;
            w = 32'h1000_0000 + 32'(off);
            fork
                begin
                    repeat (off) @(negedge clk);
                    cpu_write(2'd0, w);
                end
                begin
                    repeat (2) @(negedge tck);
                    tx_scan(r, d);
                end
            join
            if (!r) tx_scan(r, d);
            chk("R5 ready once", {255'd0, r}, 256'd1);
            chk("R5 word", {224'd0, d}, {224'd0, w});
            tx_scan(r, d);
            chk("R5 consumed", {255'd0, r}, 256'd0);
        end

        // R9: full cache line
        ir_load(2'd3);
        lv = '0;
        lv[31:0] = 32'h0000_4A60;
        for (int i = 0; i < 8; i++) lv[32 + 32*i +: 32] = 32'hC0DE_0000 + 32'(i * 17);
        scan_bits(lv, 288);
        chk("R9 inval", {255'd0, ic_inval}, 256'd1);
        chk("R9 inval addr", {224'd0, ic_addr}, {224'd0, 32'h0000_4A60});
        chk("R9 wr not yet", {255'd0, ic_wr}, 256'd0);
        @(negedge tck);
        chk("R9 wr", {254'd0, ic_wr, ic_inval}, 256'd2);
        chk("R9 line", ic_line, lv[287:32]);
        chk("R9 wr addr", {224'd0, ic_addr}, {224'd0, 32'h0000_4A60});
        @(negedge tck);
        chk("R9 pulses end", {254'd0, ic_wr, ic_inval}, 256'd0);

        // R10: short and long scans are dropped; a following full scan works
        scan_bits(lv, 287);
        no_pulse("R10 short");
        scan_bits(lv, 289);
        no_pulse("R10 long");
        lv[31:0] = 32'h0000_0020;
        scan_bits(lv, 288);
        chk("R10 recount", {224'd0, ic_addr, 254'd0, ic_inval}, {224'd0, 32'h20, 255'd1});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule